// File: doc/BRIEF.md
# Conditional verification retire controller

This block is the commit stage that sits between an in-order completion queue and a lightweight result checker. Each finished instruction enters the queue with a one-bit suspect flag, set upstream by a value predictor when the result looks doubtful. Flagged entries must pass the checker before they commit. Unflagged entries commit without being checked. Entries always leave the queue in program order, up to `RET_W` per cycle.

The checker is reached over `CHK_BW` valid/ready request lanes, one or two in practice. Lane k offers the entry k places behind the oldest one. A returned result names the queue slot it belongs to. When occupancy reaches the high-water mark `HWM`, the block stops sending new requests. The oldest entries that are not out at the checker then commit unchecked, so the core is not held back. An entry whose check is in flight stays until its result returns.

A failed check clears the whole queue and raises a one-cycle flush pulse that carries the payload of the failing entry. The recovery logic uses that payload to replay from that point. Two counters track how many flagged instructions were checked and how many were skipped.

Top module: `cv_retire_ctrl`

## Requirements
- R1: After reset the queue is empty: `alloc_ready_o` is 1, and `ret_valid_o`, `chk_valid_o`, `flush_o`, `cnt_checked_o` and `cnt_skipped_o` are all 0.
- R2: An entry allocated with `alloc_mark_i`=0 is offered on retire slot 0 in the cycle after allocation when it is the oldest. It has `ret_checked_o`=0 and its payload on `ret_data_o`, and it is never offered to the checker.
- R3: Below the high-water mark, a flagged entry is not retired until an `rsp_ok_i`=1 result for its slot has returned. It is then retired with `ret_checked_o`=1 in the cycle after that result.
- R4: Retirement is in program order. Retire slot k (payload bits k*DATA_W up) carries the k-th oldest entry, and `ret_valid_o` is always a contiguous run of ones from bit 0. A younger entry never retires while an older one waits.
- R5: Request lane k (index bits k*PTR_W up, payload bits k*DATA_W up) is valid when the k-th oldest entry is flagged, not yet sent and not yet checked. Up to `CHK_BW` lanes can be accepted in one cycle. After `chk_valid_o[k]` and `chk_ready_i[k]` are both high at an edge, that entry is no longer offered.
- R6: While occupancy is at or above `HWM`, no request lane is valid. The oldest entries that are not waiting on the checker retire with `ret_checked_o`=0 even when they are flagged.
- R7: An entry already accepted by the checker is never skipped. Under congestion it blocks retirement until its result returns.
- R8: A result with `rsp_ok_i`=0 for a slot that is out at the checker drops `alloc_ready_o` in that cycle. In the next cycle `flush_o` is 1 for exactly one cycle and `flush_id_o` holds the failing entry's payload. All entries are gone, and an allocation offered during that cycle is discarded.
- R9: A result naming a slot that is not out at the checker has no effect. In particular it raises no flush.
- R10: `cnt_checked_o` increments by one for each retired entry that had passed the checker. `cnt_skipped_o` increments by one for each flagged entry that retired unchecked.
- R11: Slots are assigned in allocation order, starting at slot 0 after reset or flush and wrapping modulo `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Finished instruction offered to the queue |
| alloc_mark_i | input | 1 | Suspect flag of the offered instruction |
| alloc_data_i | input | DATA_W | Payload (instruction tag/result) |
| alloc_ready_o | output | 1 | Queue accepts an allocation this cycle |
| chk_valid_o | output | CHK_BW | Request valid per checker lane |
| chk_ready_i | input | CHK_BW | Checker accepts request per lane |
| chk_idx_o | output | CHK_BW*PTR_W | Slot index per lane |
| chk_data_o | output | CHK_BW*DATA_W | Payload per lane |
| rsp_valid_i | input | CHK_BW | Result valid per lane |
| rsp_idx_i | input | CHK_BW*PTR_W | Slot index of each result |
| rsp_ok_i | input | CHK_BW | 1 = result matched, 0 = mismatch |
| ret_valid_o | output | RET_W | Entry retires this cycle, per slot |
| ret_checked_o | output | RET_W | Retiring entry was verified |
| ret_data_o | output | RET_W*DATA_W | Payload per retire slot |
| flush_o | output | 1 | One-cycle pipeline flush request |
| flush_id_o | output | DATA_W | Payload of the failing entry |
| cnt_checked_o | output | STAT_W | Count of verified retirements |
| cnt_skipped_o | output | STAT_W | Count of flagged entries retired unchecked |

## Verification
The main function is tried with four kinds of stream. A lone unflagged entry shows that checking is bypassed. A lone flagged entry held against a stalled checker shows that retirement waits on the result. A pair of flagged entries shows that both lanes issue and complete in one cycle. A flagged entry followed by an unflagged one shows that order is kept. A stalled checker with the queue filled to the high-water mark separates the skip path from the wait path. Filling the queue behind an in-flight head separates "not sent" from "sent but pending". Mismatch and stale results, including an allocation offered during the flush pulse, tell a real failure apart from one the block must ignore.

// File: rtl/cvr_pkg.sv
package cvr_pkg;
  typedef struct packed {
    logic vld;
    logic mark;
    logic iss;   // out at the checker
    logic done;  // checker returned ok
  } ent_st_t;

  function automatic int unsigned wrap_idx(int unsigned p, int unsigned a, int unsigned d);
    return (p + a) % d;
  endfunction
endpackage

// File: rtl/cvr_issue.sv
module cvr_issue
  import cvr_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CHK_BW = 2,
  parameter int unsigned PTR_W  = 3
) (
  input  logic [PTR_W-1:0]             head_i,
  input  ent_st_t                      st_i [DEPTH],
  input  logic                         cong_i,
  input  logic                         block_i,
  output logic [CHK_BW-1:0]            lane_vld_o,
  output logic [CHK_BW-1:0][PTR_W-1:0] lane_idx_o
);
  for (genvar l = 0; l < CHK_BW; l++) begin : g_lane
    ent_st_t s;
    assign lane_idx_o[l] = PTR_W'(wrap_idx(int'(head_i), l, DEPTH));
    assign s             = st_i[lane_idx_o[l]];
    assign lane_vld_o[l] = s.vld && s.mark && !s.iss && !s.done && !cong_i && !block_i;
  end
endmodule

// File: rtl/cvr_retire.sv
module cvr_retire
  import cvr_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned RET_W = 2,
  parameter int unsigned PTR_W = 3
) (
  input  logic [PTR_W-1:0]            head_i,
  input  ent_st_t                     st_i [DEPTH],
  input  logic                        cong_i,
  input  logic                        block_i,
  output logic [RET_W-1:0]            ret_en_o,
  output logic [RET_W-1:0]            ret_chk_o,
  output logic [RET_W-1:0]            ret_skip_o,
  output logic [RET_W-1:0][PTR_W-1:0] ret_idx_o
);
  always_comb begin
    logic    go;
    logic    ok;
    ent_st_t s;
    go = !block_i;
    for (int k = 0; k < RET_W; k++) begin
      ret_idx_o[k]  = PTR_W'(wrap_idx(int'(head_i), k, DEPTH));
      s             = st_i[ret_idx_o[k]];
      // unmarked, verified, or congested and not pending at the checker
      ok            = s.vld && (!s.mark || s.done || (cong_i && !s.iss));
      ret_en_o[k]   = go && ok;
      ret_chk_o[k]  = go && ok && s.done;
      ret_skip_o[k] = go && ok && s.mark && !s.done;
      go            = go && ok;
    end
  end
endmodule

// File: rtl/cvr_stat.sv
module cvr_stat #(
  parameter int unsigned RET_W  = 2,
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RET_W-1:0]  chk_i,
  input  logic [RET_W-1:0]  skip_i,
  output logic [STAT_W-1:0] cnt_chk_o,
  output logic [STAT_W-1:0] cnt_skip_o
);
  logic [STAT_W-1:0] n_chk, n_skip;

  always_comb begin
    n_chk  = '0;
    n_skip = '0;
    for (int k = 0; k < RET_W; k++) begin
      n_chk  = n_chk  + STAT_W'(chk_i[k]);
      n_skip = n_skip + STAT_W'(skip_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_chk_o  <= '0;
      cnt_skip_o <= '0;
    end else begin
      cnt_chk_o  <= cnt_chk_o + n_chk;
      cnt_skip_o <= cnt_skip_o + n_skip;
    end
  end
endmodule

// File: rtl/cv_retire_ctrl.sv
// DEPTH must be a power of two.
module cv_retire_ctrl
  import cvr_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHK_BW = 2,
  parameter int unsigned RET_W  = 2,
  parameter int unsigned HWM    = 6,
  parameter int unsigned STAT_W = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     alloc_valid_i,
  input  logic                     alloc_mark_i,
  input  logic [DATA_W-1:0]        alloc_data_i,
  output logic                     alloc_ready_o,
  output logic [CHK_BW-1:0]        chk_valid_o,
  input  logic [CHK_BW-1:0]        chk_ready_i,
  output logic [CHK_BW*PTR_W-1:0]  chk_idx_o,
  output logic [CHK_BW*DATA_W-1:0] chk_data_o,
  input  logic [CHK_BW-1:0]        rsp_valid_i,
  input  logic [CHK_BW*PTR_W-1:0]  rsp_idx_i,
  input  logic [CHK_BW-1:0]        rsp_ok_i,
  output logic [RET_W-1:0]         ret_valid_o,
  output logic [RET_W-1:0]         ret_checked_o,
  output logic [RET_W*DATA_W-1:0]  ret_data_o,
  output logic                     flush_o,
  output logic [DATA_W-1:0]        flush_id_o,
  output logic [STAT_W-1:0]        cnt_checked_o,
  output logic [STAT_W-1:0]        cnt_skipped_o
);
  ent_st_t           st_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  occ_q;
  logic              flush_q;
  logic [DATA_W-1:0] flush_id_q;

  logic                         cong, mism, do_alloc;
  logic [DATA_W-1:0]            mism_id;
  logic [CHK_BW-1:0]            rsp_hit_ok;
  logic [CHK_BW-1:0][PTR_W-1:0] rsp_idx, lane_idx;
  logic [CHK_BW-1:0]            lane_vld;
  logic [RET_W-1:0]             ret_en, ret_chk, ret_skip;
  logic [RET_W-1:0][PTR_W-1:0]  ret_idx;
  logic [CNT_W-1:0]             n_ret;

  assign rsp_idx = rsp_idx_i;
  assign cong    = occ_q >= CNT_W'(HWM);

  // result matching; lowest failing lane names the flush
  always_comb begin
    mism       = 1'b0;
    mism_id    = '0;
    rsp_hit_ok = '0;
    for (int l = CHK_BW - 1; l >= 0; l--) begin
      if (rsp_valid_i[l] && st_q[rsp_idx[l]].vld && st_q[rsp_idx[l]].iss) begin
        if (rsp_ok_i[l]) begin
          rsp_hit_ok[l] = 1'b1;
        end else begin
          mism    = 1'b1;
          mism_id = data_q[rsp_idx[l]];
        end
      end
    end
  end

  cvr_issue #(.DEPTH(DEPTH), .CHK_BW(CHK_BW), .PTR_W(PTR_W)) u_issue (
    .head_i    (head_q),
    .st_i      (st_q),
    .cong_i    (cong),
    .block_i   (mism),
    .lane_vld_o(lane_vld),
    .lane_idx_o(lane_idx)
  );

  cvr_retire #(.DEPTH(DEPTH), .RET_W(RET_W), .PTR_W(PTR_W)) u_retire (
    .head_i    (head_q),
    .st_i      (st_q),
    .cong_i    (cong),
    .block_i   (mism),
    .ret_en_o  (ret_en),
    .ret_chk_o (ret_chk),
    .ret_skip_o(ret_skip),
    .ret_idx_o (ret_idx)
  );

  cvr_stat #(.RET_W(RET_W), .STAT_W(STAT_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chk_i     (ret_chk),
    .skip_i    (ret_skip),
    .cnt_chk_o (cnt_checked_o),
    .cnt_skip_o(cnt_skipped_o)
  );

  always_comb begin
    n_ret = '0;
    for (int k = 0; k < RET_W; k++) n_ret = n_ret + CNT_W'(ret_en[k]);
  end

  assign alloc_ready_o = (occ_q < CNT_W'(DEPTH)) && !flush_q && !mism;
  assign do_alloc      = alloc_valid_i && alloc_ready_o;

  always_comb begin
    chk_valid_o = lane_vld;
    chk_idx_o   = lane_idx;
    for (int l = 0; l < CHK_BW; l++) chk_data_o[l*DATA_W +: DATA_W] = data_q[lane_idx[l]];
    ret_valid_o   = ret_en;
    ret_checked_o = ret_chk;
    for (int k = 0; k < RET_W; k++) ret_data_o[k*DATA_W +: DATA_W] = data_q[ret_idx[k]];
  end

  assign flush_o    = flush_q;
  assign flush_id_o = flush_id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= '0;
        data_q[i] <= '0;
      end
      head_q     <= '0;
      tail_q     <= '0;
      occ_q      <= '0;
      flush_q    <= 1'b0;
      flush_id_q <= '0;
    end else if (mism) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
      head_q     <= '0;
      tail_q     <= '0;
      occ_q      <= '0;
      flush_q    <= 1'b1;
      flush_id_q <= mism_id;
    end else begin
      flush_q <= 1'b0;
      for (int l = 0; l < CHK_BW; l++) begin
        if (rsp_hit_ok[l]) begin
          st_q[rsp_idx[l]].done <= 1'b1;
          st_q[rsp_idx[l]].iss  <= 1'b0;
        end
        if (lane_vld[l] && chk_ready_i[l]) st_q[lane_idx[l]].iss <= 1'b1;
      end
      for (int k = 0; k < RET_W; k++) begin
        if (ret_en[k]) st_q[ret_idx[k]] <= '0;
      end
      if (do_alloc) begin
        st_q[tail_q]   <= '{vld: 1'b1, mark: alloc_mark_i, iss: 1'b0, done: 1'b0};
        data_q[tail_q] <= alloc_data_i;
        tail_q         <= PTR_W'(wrap_idx(int'(tail_q), 1, DEPTH));
      end
      head_q <= PTR_W'(wrap_idx(int'(head_q), int'(n_ret), DEPTH));
      occ_q  <= occ_q + CNT_W'(do_alloc) - n_ret;
    end
  end
endmodule

// File: rtl/cv_retire_ctrl_chk.sv
module cv_retire_ctrl_chk #(
  parameter int unsigned RET_W  = 2,
  parameter int unsigned CHK_BW = 2,
  parameter int unsigned HWM    = 6,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned STAT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_o,
  input logic              alloc_ready_o,
  input logic [RET_W-1:0]  ret_valid_o,
  input logic [CHK_BW-1:0] chk_valid_o,
  input logic [CNT_W-1:0]  occ_i,
  input logic [STAT_W-1:0] cnt_skipped_o
);
  p_flush_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);

  p_no_alloc_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !alloc_ready_o);

  p_flush_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (occ_i == '0 && ret_valid_o == '0));

  p_ret_contig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_o & (ret_valid_o + 1'b1)) == '0);

  p_cong_no_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i >= CNT_W'(HWM)) |-> (chk_valid_o == '0));

  p_skip_only_cong_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_skipped_o != $past(cnt_skipped_o)) |-> ($past(occ_i) >= CNT_W'(HWM)));
endmodule

bind cv_retire_ctrl cv_retire_ctrl_chk #(
  .RET_W(RET_W), .CHK_BW(CHK_BW), .HWM(HWM), .CNT_W(CNT_W), .STAT_W(STAT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_o      (flush_o),
  .alloc_ready_o(alloc_ready_o),
  .ret_valid_o  (ret_valid_o),
  .chk_valid_o  (chk_valid_o),
  .occ_i        (occ_q),
  .cnt_skipped_o(cnt_skipped_o)
);

// File: tb/cv_retire_ctrl_tb_top.sv
`timescale 1ns/1ps
module cv_retire_ctrl_tb_top;
  localparam int DW = 16;
  localparam int PW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          alloc_valid_i = 1'b0;
  logic          alloc_mark_i = 1'b0;
  logic [DW-1:0] alloc_data_i = '0;
  logic          alloc_ready_o;
  logic [1:0]    chk_valid_o;
  logic [1:0]    chk_ready_i = '0;
  logic [2*PW-1:0] chk_idx_o;
  logic [2*DW-1:0] chk_data_o;
  logic [1:0]    rsp_valid_i = '0;
  logic [2*PW-1:0] rsp_idx_i = '0;
  logic [1:0]    rsp_ok_i = '0;
  logic [1:0]    ret_valid_o;
  logic [1:0]    ret_checked_o;
  logic [2*DW-1:0] ret_data_o;
  logic          flush_o;
  logic [DW-1:0] flush_id_o;
  logic [15:0]   cnt_checked_o, cnt_skipped_o;

  int checks = 0;
  int errors = 0;
  int tail_m = 0;

  always #4 clk_i = ~clk_i;

  cv_retire_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_mark_i(alloc_mark_i),
    .alloc_data_i(alloc_data_i), .alloc_ready_o(alloc_ready_o),
    .chk_valid_o(chk_valid_o), .chk_ready_i(chk_ready_i),
    .chk_idx_o(chk_idx_o), .chk_data_o(chk_data_o),
    .rsp_valid_i(rsp_valid_i), .rsp_idx_i(rsp_idx_i), .rsp_ok_i(rsp_ok_i),
    .ret_valid_o(ret_valid_o), .ret_checked_o(ret_checked_o),
    .ret_data_o(ret_data_o), .flush_o(flush_o), .flush_id_o(flush_id_o),
    .cnt_checked_o(cnt_checked_o), .cnt_skipped_o(cnt_skipped_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic alloc(input logic m, input logic [DW-1:0] d);
    alloc_valid_i = 1'b1;
    alloc_mark_i  = m;
    alloc_data_i  = d;
    tick();
    alloc_valid_i = 1'b0;
    tail_m = (tail_m + 1) % 8;
  endtask

  task automatic respond(input int lane, input logic [PW-1:0] idx, input logic ok);
    rsp_valid_i[lane]              = 1'b1;
    rsp_idx_i[lane*PW +: PW]       = idx;
    rsp_ok_i[lane]                 = ok;
    tick();
    rsp_valid_i = '0;
    rsp_ok_i    = '0;
  endtask

  task automatic grant(input logic [1:0] lanes);
    chk_ready_i = lanes;
    tick();
    chk_ready_i = '0;
  endtask

  task automatic t_reset();
    check("R1", "alloc_ready", alloc_ready_o, 1);
    check("R1", "ret_valid", ret_valid_o, 0);
    check("R1", "chk_valid", chk_valid_o, 0);
    check("R1", "flush", flush_o, 0);
    check("R1", "cnt_checked", cnt_checked_o, 0);
    check("R1", "cnt_skipped", cnt_skipped_o, 0);
  endtask

  task automatic t_unmarked();
    alloc(1'b0, 16'h00A1);               // slot 0
    check("R2", "ret_valid", ret_valid_o, 2'b01);
    check("R2", "ret_checked", ret_checked_o, 0);
    check("R2", "ret_data", ret_data_o[DW-1:0], 16'h00A1);
    check("R2", "chk_valid", chk_valid_o, 0);
    tick();
    check("R2", "drained", ret_valid_o, 0);
  endtask

  task automatic t_marked();
    alloc(1'b1, 16'h00B2);               // slot 1
    check("R3", "held", ret_valid_o, 0);
    check("R5", "lane0 valid", chk_valid_o, 2'b01);
    check("R11", "lane0 idx", chk_idx_o[PW-1:0], 1);
    check("R5", "lane0 data", chk_data_o[DW-1:0], 16'h00B2);
    tick(); tick();
    check("R3", "still held", ret_valid_o, 0);
    check("R5", "req held", chk_valid_o, 2'b01);
    grant(2'b01);
    check("R5", "req dropped", chk_valid_o, 0);
    check("R3", "pending", ret_valid_o, 0);
    respond(0, 3'd1, 1'b1);
    check("R3", "ret after ok", ret_valid_o, 2'b01);
    check("R3", "checked flag", ret_checked_o, 2'b01);
    tick();
    check("R10", "cnt_checked", cnt_checked_o, 1);
  endtask

  task automatic t_dual();
    alloc(1'b1, 16'h00C3);               // slot 2
    alloc(1'b1, 16'h00D4);               // slot 3
    check("R5", "two lanes", chk_valid_o, 2'b11);
    check("R5", "lane0 idx", chk_idx_o[PW-1:0], 2);
    check("R5", "lane1 idx", chk_idx_o[2*PW-1:PW], 3);
    check("R5", "lane1 data", chk_data_o[2*DW-1:DW], 16'h00D4);
    grant(2'b11);
    check("R5", "both dropped", chk_valid_o, 0);
    rsp_valid_i = 2'b11;
    rsp_idx_i   = {3'd3, 3'd2};
    rsp_ok_i    = 2'b11;
    tick();
    rsp_valid_i = '0;
    rsp_ok_i    = '0;
    check("R3", "dual retire", ret_valid_o, 2'b11);
    check("R3", "dual checked", ret_checked_o, 2'b11);
    check("R4", "slot1 data", ret_data_o[2*DW-1:DW], 16'h00D4);
    tick();
    check("R10", "cnt_checked", cnt_checked_o, 3);
  endtask

  task automatic t_order();
    alloc(1'b1, 16'h00E5);               // slot 4
    alloc(1'b0, 16'h00F6);               // slot 5
    check("R4", "younger waits", ret_valid_o, 0);
    check("R5", "only head", chk_valid_o, 2'b01);
    grant(2'b01);
    respond(0, 3'd4, 1'b1);
    check("R4", "both retire", ret_valid_o, 2'b11);
    check("R4", "checked mix", ret_checked_o, 2'b01);
    check("R4", "slot0 data", ret_data_o[DW-1:0], 16'h00E5);
    check("R4", "slot1 data", ret_data_o[2*DW-1:DW], 16'h00F6);
    tick();
    check("R10", "cnt_checked", cnt_checked_o, 4);
  endtask

  task automatic t_congest();
    for (int j = 0; j < 5; j++) alloc(1'b1, 16'h0100 + 16'(j));  // slots 6,7,0,1,2
    check("R3", "below hwm holds", ret_valid_o, 0);
    alloc(1'b1, 16'h0105);               // slot 3, occupancy 6
    check("R6", "skip retire", ret_valid_o, 2'b11);
    check("R6", "unchecked", ret_checked_o, 0);
    check("R6", "no requests", chk_valid_o, 0);
    check("R6", "oldest first", ret_data_o[DW-1:0], 16'h0100);
    tick();
    check("R10", "cnt_skipped", cnt_skipped_o, 2);
    check("R6", "below hwm stop", ret_valid_o, 0);
    check("R6", "requests resume", chk_valid_o, 2'b11);
    check("R11", "wrapped idx", chk_idx_o[PW-1:0], 0);
    check("R11", "wrapped data", chk_data_o[DW-1:0], 16'h0102);
  endtask

  task automatic t_flush();
    grant(2'b11);                        // slots 0 and 1 out
    rsp_valid_i[0] = 1'b1;
    rsp_idx_i[PW-1:0] = 3'd0;
    rsp_ok_i[0] = 1'b0;
    #1;
    check("R8", "ready low on mismatch", alloc_ready_o, 0);
    tick();
    rsp_valid_i = '0;
    check("R8", "flush pulse", flush_o, 1);
    check("R8", "flush id", flush_id_o, 16'h0102);
    check("R8", "ready low", alloc_ready_o, 0);
    check("R8", "queue empty", ret_valid_o, 0);
    check("R8", "no requests", chk_valid_o, 0);
    alloc_valid_i = 1'b1;
    alloc_mark_i  = 1'b0;
    alloc_data_i  = 16'h0BAD;
    tick();
    alloc_valid_i = 1'b0;
    tail_m = 0;
    check("R8", "pulse ends", flush_o, 0);
    check("R8", "ready back", alloc_ready_o, 1);
    check("R8", "alloc discarded", ret_valid_o, 0);
    respond(1, 3'd1, 1'b0);              // stale slot
    check("R9", "stale ignored", flush_o, 0);
    check("R9", "still empty", ret_valid_o, 0);
  endtask

  task automatic t_inflight();
    alloc(1'b1, 16'h0200);               // slot 0 after flush
    check("R11", "restart at 0", chk_idx_o[PW-1:0], 0);
    grant(2'b01);
    for (int j = 1; j < 6; j++) alloc(1'b0, 16'h0200 + 16'(j));
    check("R7", "pending head blocks", ret_valid_o, 0);
    check("R6", "no requests", chk_valid_o, 0);
    respond(0, 3'd0, 1'b1);
    check("R7", "head retires", ret_valid_o, 2'b11);
    check("R7", "head checked", ret_checked_o, 2'b01);
    tick();
    check("R2", "unmarked drain", ret_valid_o, 2'b11);
    tick();
    check("R2", "unmarked drain 2", ret_valid_o, 2'b11);
    tick();
    check("R2", "empty", ret_valid_o, 0);
    check("R10", "cnt_checked final", cnt_checked_o, 5);
    check("R10", "cnt_skipped final", cnt_skipped_o, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    #1;
    t_reset();
    tick();
    t_unmarked();
    t_marked();
    t_dual();
    t_order();
    t_congest();
    t_flush();
    t_inflight();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule